// File: doc/BRIEF.md
# External Bus Width Adapter

The adapter sits between a 32-bit internal transfer port and a narrow static-memory port that is 8 or 16 bits wide. It accepts one transfer at a time: an address, a size (byte, half-word or word), a direction and write data. It breaks the transfer into as many external cycles as the device width requires. For each cycle it works out the external address, the byte lane to steer, the active-low byte masks and whether the write strobe may be used. It then hands the cycle to a separate timing engine through a one-cycle start pulse and waits for that engine's done pulse.

On reads, each returned slice is packed into its little-endian position in a 32-bit word. Lanes that the transfer does not touch read as zero. The assembled word is presented together with a single completion pulse after the last external cycle. Chip select stays asserted from the first external cycle to the last, so a split transfer appears on the memory side as one burst whose address steps.

The device width, the read-mask enable and the write-strobe disable are sampled when a transfer is accepted. Changes to them while a transfer runs have no effect until the next acceptance.

Top module: `ebw_adapter`

## Requirements
- R1: `cfg_width_i[0]` selects the device width (0 = 8-bit, 1 = 16-bit) and `cfg_width_i[1]` is ignored. All three configuration inputs are sampled when a request is accepted and held for the whole transfer.
- R2: `req_size_i` is encoded 00 = byte, 01 = half-word, 1x = word. The number of external cycles is 1/2/4 for byte/half/word on an 8-bit device and 1/1/2 on a 16-bit device. No further start pulse follows the last cycle.
- R3: On an 8-bit device, the external address is a byte address. Its two low bits are the internal byte lane: `addr[1:0]` for a byte, `{addr[1],0}` then +1 for a half-word, and 0..3 for a word. The upper bits are `addr[24:2]`. On writes, `ext_wdata_o[7:0]` carries that internal lane and `ext_wdata_o[15:8]` is zero.
- R4: On a 16-bit device, the external address is the half-word index `{addr[24:2], h}`. Here h is `addr[1]` for a byte or half-word, and 0 then 1 for a word. On writes, `ext_wdata_o` carries internal bits `[16h+15:16h]`.
- R5: The byte masks `ext_be_n_o` are active low; bit 0 covers external data bits 7:0. On writes to an 8-bit device they are 2'b10. On writes to a 16-bit device a byte transfer gives 2'b10 when `addr[0]`=0 and 2'b01 when `addr[0]`=1, and half-word and word transfers give 2'b00.
- R6: On reads, `ext_be_n_o` follows the R5 write pattern when the read-mask enable is set, and is 2'b00 when it is clear.
- R7: `ext_we_en_o` is high during the cycles of a write transfer when write-strobe disable is clear. It stays low when write-strobe disable is set, and it is low for reads.
- R8: At completion of a read, `req_rdata_o` holds the slices in their little-endian lanes with untouched lanes zero. A 16-bit byte read keeps only the addressed byte of the returned half. After a write, `req_rdata_o` is zero.
- R9: `cyc_start_o` is a one-cycle pulse. It occurs in the cycle after acceptance and in the cycle after each non-final `cyc_done_i`. `ext_cs_n_o` is low from the first start until completion. `ext_addr_o` is stable between starts.
- R10: `req_done_o` is a single-cycle pulse in the cycle after the final `cyc_done_i`, with `req_ready_o` high in the same cycle. A request presented in that cycle is accepted.
- R11: After reset `req_ready_o`=1, `ext_cs_n_o`=1, `cyc_start_o`=0, `req_done_o`=0 and `req_rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_width_i | input | 2 | Device width select, bit 0 decoded |
| cfg_rd_mask_en_i | input | 1 | Drive byte masks on reads |
| cfg_we_off_i | input | 1 | Keep write strobe unused |
| req_valid_i | input | 1 | Transfer request |
| req_ready_o | output | 1 | Adapter idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Transfer size |
| req_addr_i | input | 25 | Internal byte address |
| req_wdata_i | input | 32 | Internal write data |
| req_done_o | output | 1 | Transfer complete pulse |
| req_rdata_o | output | 32 | Assembled read data |
| cyc_start_o | output | 1 | Start of one external cycle |
| cyc_done_i | input | 1 | External cycle finished |
| cyc_write_o | output | 1 | Direction of current external cycle |
| ext_cs_n_o | output | 1 | Chip select, active low |
| ext_addr_o | output | 25 | External address |
| ext_be_n_o | output | 2 | Byte masks, active low |
| ext_we_en_o | output | 1 | Write strobe permitted |
| ext_wdata_o | output | 16 | External write data |
| ext_rdata_i | input | 16 | External read data |

## Verification
The completion pulse of one transfer and the acceptance of the next can fall in the same cycle. The bench provokes this on every other transfer by presenting the next request in the exact cycle in which `req_done_o` is checked. It then requires the following cycle to carry a start pulse with the new transfer's address and lanes. The sweep also flips every configuration input just after acceptance. It judges the mid-transfer changes by requiring each external cycle to match the configuration captured at acceptance.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } state_e;

  typedef struct packed {
    logic wide;
    logic rd_mask;
    logic we_off;
  } cfg_t;

  // number of external cycles for a size code on the chosen device width
  function automatic logic [2:0] cyc_count(input logic wide, input logic [1:0] size);
    if (wide) return size[1] ? 3'd2 : 3'd1;
    if (size[1]) return 3'd4;
    return size[0] ? 3'd2 : 3'd1;
  endfunction
endpackage

// File: rtl/ebw_step_map.sv
module ebw_step_map (
  input  logic       wide_i,
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  input  logic [1:0] step_i,
  input  logic       write_i,
  input  logic       rd_mask_i,
  output logic [1:0] lane_o,
  output logic [1:0] be_n_o
);
  logic [1:0] be_mask;

  always_comb begin
    if (wide_i) begin
      lane_o = {size_i[1] ? step_i[0] : addr_lo_i[1], 1'b0};
    end else if (size_i[1]) begin
      lane_o = step_i;
    end else if (size_i[0]) begin
      lane_o = {addr_lo_i[1], step_i[0]};
    end else begin
      lane_o = addr_lo_i;
    end
  end

  always_comb begin
    if (!wide_i) be_mask = 2'b10;
    else if (size_i == 2'b00) be_mask = addr_lo_i[0] ? 2'b01 : 2'b10;
    else be_mask = 2'b00;
    be_n_o = (write_i || rd_mask_i) ? be_mask : 2'b00;
  end
endmodule

// File: rtl/ebw_wr_steer.sv
module ebw_wr_steer #(
  parameter int IW = 32,
  parameter int EW = 16
) (
  input  logic          wide_i,
  input  logic [1:0]    lane_i,
  input  logic [IW-1:0] wdata_i,
  output logic [EW-1:0] ext_wdata_o
);
  localparam int BW = IW / 4;

  always_comb begin
    if (wide_i) ext_wdata_o = wdata_i[lane_i[1]*EW +: EW];
    else        ext_wdata_o = {{(EW-BW){1'b0}}, wdata_i[lane_i*BW +: BW]};
  end
endmodule

// File: rtl/ebw_rd_pack.sv
module ebw_rd_pack #(
  parameter int IW = 32,
  parameter int EW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          capture_i,
  input  logic          wide_i,
  input  logic          byte_i,
  input  logic          byte_hi_i,
  input  logic [1:0]    lane_i,
  input  logic [EW-1:0] ext_rdata_i,
  output logic [IW-1:0] acc_next_o
);
  localparam int BW = IW / 4;

  logic [IW-1:0] acc_q;
  logic [EW-1:0] slice;

  always_comb begin
    slice = ext_rdata_i;
    if (byte_i) slice = byte_hi_i ? {ext_rdata_i[EW-1:BW], {BW{1'b0}}}
                                  : {{(EW-BW){1'b0}}, ext_rdata_i[BW-1:0]};
    acc_next_o = acc_q;
    if (capture_i) begin
      if (wide_i) acc_next_o[lane_i[1]*EW +: EW] = slice;
      else        acc_next_o[lane_i*BW +: BW]   = ext_rdata_i[BW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else              acc_q <= acc_next_o;
  end
endmodule

// File: rtl/ebw_adapter.sv
module ebw_adapter
  import ebw_pkg::*;
#(
  parameter int AW = 25,
  parameter int IW = 32,
  parameter int EW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cfg_width_i,
  input  logic          cfg_rd_mask_en_i,
  input  logic          cfg_we_off_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [1:0]    req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [IW-1:0] req_wdata_i,
  output logic          req_done_o,
  output logic [IW-1:0] req_rdata_o,
  output logic          cyc_start_o,
  input  logic          cyc_done_i,
  output logic          cyc_write_o,
  output logic          ext_cs_n_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [1:0]    ext_be_n_o,
  output logic          ext_we_en_o,
  output logic [EW-1:0] ext_wdata_o,
  input  logic [EW-1:0] ext_rdata_i
);
  state_e        state_q;
  cfg_t          cfg_q;
  logic [1:0]    step_q;
  logic [2:0]    cnt_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic [IW-1:0] wdata_q;
  logic          write_q;
  logic          done_q;
  logic [IW-1:0] rdata_q;

  logic          accept, last, cyc_end;
  logic [1:0]    lane;
  logic [1:0]    be_n;
  logic [IW-1:0] acc_next;

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign last    = ({1'b0, step_q} == cnt_q - 3'd1);
  assign cyc_end = (state_q == ST_WAIT) && cyc_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      step_q  <= '0;
      cnt_q   <= 3'd1;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= cyc_end && last;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cfg_q   <= '{wide: cfg_width_i[0], rd_mask: cfg_rd_mask_en_i, we_off: cfg_we_off_i};
          cnt_q   <= cyc_count(cfg_width_i[0], req_size_i);
          step_q  <= '0;
          addr_q  <= req_addr_i;
          size_q  <= req_size_i;
          wdata_q <= req_wdata_i;
          write_q <= req_write_i;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (cyc_done_i) begin
          if (last) begin
            state_q <= ST_IDLE;
            rdata_q <= acc_next;
          end else begin
            step_q  <= step_q + 2'd1;
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ebw_step_map i_step_map (
    .wide_i    (cfg_q.wide),
    .size_i    (size_q),
    .addr_lo_i (addr_q[1:0]),
    .step_i    (step_q),
    .write_i   (write_q),
    .rd_mask_i (cfg_q.rd_mask),
    .lane_o    (lane),
    .be_n_o    (be_n)
  );

  ebw_wr_steer #(.IW(IW), .EW(EW)) i_wr_steer (
    .wide_i      (cfg_q.wide),
    .lane_i      (lane),
    .wdata_i     (wdata_q),
    .ext_wdata_o (ext_wdata_o)
  );

  ebw_rd_pack #(.IW(IW), .EW(EW)) i_rd_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .capture_i   (cyc_end && !write_q),
    .wide_i      (cfg_q.wide),
    .byte_i      (size_q == 2'b00),
    .byte_hi_i   (addr_q[0]),
    .lane_i      (lane),
    .ext_rdata_i (ext_rdata_i),
    .acc_next_o  (acc_next)
  );

  // 8-bit: byte address; 16-bit: half-word index
  assign ext_addr_o  = cfg_q.wide ? {1'b0, addr_q[AW-1:2], lane[1]}
                                  : {addr_q[AW-1:2], lane};
  assign req_ready_o = (state_q == ST_IDLE);
  assign cyc_start_o = (state_q == ST_ISSUE);
  assign ext_cs_n_o  = (state_q == ST_IDLE);
  assign cyc_write_o = write_q;
  assign ext_be_n_o  = (state_q == ST_IDLE) ? 2'b11 : be_n;
  assign ext_we_en_o = (state_q != ST_IDLE) && write_q && !cfg_q.we_off;
  assign req_done_o  = done_q;
  assign req_rdata_o = rdata_q;
endmodule

// File: rtl/ebw_adapter_chk.sv
module ebw_adapter_chk #(
  parameter int AW = 25
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          req_done_o,
  input logic          cyc_start_o,
  input logic          cyc_done_i,
  input logic          cyc_write_o,
  input logic          ext_cs_n_o,
  input logic [AW-1:0] ext_addr_o,
  input logic          ext_we_en_o
);
  a_r9_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);

  a_r9_cs_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> !ext_cs_n_o);

  a_r9_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> ($past(req_ready_o) || $past(cyc_done_i)));

  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_cs_n_o && !cyc_start_o) |-> $stable(ext_addr_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);

  a_r10_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> req_ready_o);

  a_r7_we_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_en_o |-> cyc_write_o);
endmodule

bind ebw_adapter ebw_adapter_chk #(.AW(AW)) i_ebw_adapter_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .req_done_o  (req_done_o),
  .cyc_start_o (cyc_start_o),
  .cyc_done_i  (cyc_done_i),
  .cyc_write_o (cyc_write_o),
  .ext_cs_n_o  (ext_cs_n_o),
  .ext_addr_o  (ext_addr_o),
  .ext_we_en_o (ext_we_en_o)
);

// File: tb/test_ebw_adapter.sv
`timescale 1ns/1ps
module test_ebw_adapter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cfg_width_i = '0;
  logic        cfg_rd_mask_en_i = 1'b0;
  logic        cfg_we_off_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_size_i = '0;
  logic [24:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_done_o;
  logic [31:0] req_rdata_o;
  logic        cyc_start_o;
  logic        cyc_done_i = 1'b0;
  logic        cyc_write_o;
  logic        ext_cs_n_o;
  logic [24:0] ext_addr_o;
  logic [1:0]  ext_be_n_o;
  logic        ext_we_en_o;
  logic [15:0] ext_wdata_o;
  logic [15:0] ext_rdata_i = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  ebw_adapter i_ebw_adapter (.*);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_xfer(input logic wr, input logic [1:0] sz, input logic [24:0] a,
                         input logic [31:0] wd, input logic [1:0] wcfg,
                         input logic rm, input logic wo, input int dly);
    logic        wide;
    int          n;
    logic [31:0] exp_r;
    logic [1:0]  ln;
    logic        h;
    logic [24:0] ea;
    logic [1:0]  eb;
    logic [15:0] ew;
    logic [15:0] rp;
    wide = wcfg[0];
    n = wide ? (sz[1] ? 2 : 1) : (sz[1] ? 4 : (sz[0] ? 2 : 1));
    exp_r = '0;
    cfg_width_i = wcfg; cfg_rd_mask_en_i = rm; cfg_we_off_i = wo;
    req_write_i = wr; req_size_i = sz; req_addr_i = a; req_wdata_i = wd;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    // R1: scramble configuration after acceptance
    cfg_width_i = {~wcfg[1], ~wcfg[0]}; cfg_rd_mask_en_i = ~rm; cfg_we_off_i = ~wo;
    for (int k = 0; k < n; k++) begin
      if (wide) begin
        h  = sz[1] ? k[0] : a[1];
        ea = {1'b0, a[24:2], h};
        ew = h ? wd[31:16] : wd[15:0];
        if (sz == 2'b00) eb = a[0] ? 2'b01 : 2'b10; else eb = 2'b00;
        ln = {h, 1'b0};
      end else begin
        if (sz[1]) ln = k[1:0];
        else if (sz[0]) ln = {a[1], k[0]};
        else ln = a[1:0];
        ea = {a[24:2], ln};
        ew = {8'h00, wd[ln*8 +: 8]};
        eb = 2'b10;
        h = 1'b0;
      end
      if (!wr && !rm) eb = 2'b00;
      check(cyc_start_o === 1'b1, "R9 start pulse", 32'(cyc_start_o), 32'd1);
      check(ext_cs_n_o === 1'b0, "R9 cs low", 32'(ext_cs_n_o), 32'd0);
      check(req_done_o === 1'b0, "R10 no early done", 32'(req_done_o), 32'd0);
      check(ext_addr_o === ea, wide ? "R4 address" : "R3 address", 32'(ext_addr_o), 32'(ea));
      check(ext_be_n_o === eb, wr ? "R5 write mask" : "R6 read mask", 32'(ext_be_n_o), 32'(eb));
      check(ext_we_en_o === (wr && !wo), "R7 write strobe", 32'(ext_we_en_o), 32'(wr && !wo));
      if (wr) check(ext_wdata_o === ew, wide ? "R4 write lane" : "R3 write lane", 32'(ext_wdata_o), 32'(ew));
      @(negedge clk_i);
      check(cyc_start_o === 1'b0 && ext_cs_n_o === 1'b0, "R9 wait state", 32'({cyc_start_o, ext_cs_n_o}), 32'd0);
      check(ext_addr_o === ea, "R9 address held", 32'(ext_addr_o), 32'(ea));
      repeat (dly) @(negedge clk_i);
      rp = 16'h3c5a ^ (16'h1111 * 16'(k + 1)) ^ a[15:0];
      ext_rdata_i = rp;
      cyc_done_i = 1'b1;
      if (!wr) begin
        if (!wide) exp_r[ln*8 +: 8] = rp[7:0];
        else if (sz == 2'b00) exp_r[h*16 +: 16] = a[0] ? {rp[15:8], 8'h00} : {8'h00, rp[7:0]};
        else exp_r[h*16 +: 16] = rp;
      end
      @(negedge clk_i);
      cyc_done_i = 1'b0;
      ext_rdata_i = '0;
    end
    check(cyc_start_o === 1'b0, "R2 cycle count", 32'(cyc_start_o), 32'd0);
    check(req_done_o === 1'b1, "R10 done pulse", 32'(req_done_o), 32'd1);
    check(req_ready_o === 1'b1 && ext_cs_n_o === 1'b1, "R10 ready with done",
          32'({req_ready_o, ext_cs_n_o}), 32'd3);
    check(req_rdata_o === exp_r, "R8 read data", req_rdata_o, exp_r);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int i;
    i = 0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(req_ready_o === 1'b1, "R11 ready", 32'(req_ready_o), 32'd1);
    check(ext_cs_n_o === 1'b1, "R11 cs", 32'(ext_cs_n_o), 32'd1);
    check(cyc_start_o === 1'b0 && req_done_o === 1'b0, "R11 pulses",
          32'({cyc_start_o, req_done_o}), 32'd0);
    check(req_rdata_o === 32'd0, "R11 rdata", req_rdata_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 4; s++)
        for (int wr = 0; wr < 2; wr++)
          for (int lo = 0; lo < 4; lo++)
            for (int rm = 0; rm < 2; rm++)
              for (int wo = 0; wo < 2; wo++) begin
                do_xfer(wr[0], s[1:0], 25'h1abcd0 ^ 25'(i << 5) ^ 25'(lo),
                        32'hc3a51e77 ^ (32'h01010101 * 32'(i)), w[1:0], rm[0], wo[0], i % 3);
                // R10: odd transfers chain directly into the done cycle
                if (i % 2 == 0) @(negedge clk_i);
                i++;
              end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule